// File: doc/BRIEF.md
# Serial Control-Register Target with Frame Checking

This block lets a host configure a front end over a four-wire serial link in SPI mode 0. The block samples the link with its own system clock. Every access is one 24-bit frame, sent MSB first while chip select is low. The frame carries a read flag, a 6-bit register address, a 16-bit data word and a check bit. Writes take effect when chip select rises. Reads return the addressed 16-bit word on the serial output, in the same frame bit positions that a write uses for data.

The block checks every frame when chip select rises. A frame with the wrong number of clock edges is dropped. So is a frame with an unknown address or, when checking is on, a frame with bad parity. Each kind of fault sets its own sticky flag in an alarm register, and the host clears a flag by writing 1 to it. Register 0 holds a fixed identity byte and a revision nibble, which are read-only. Writing its reset bit returns every writable control field to zero, and the bit reads back as zero. The enable and control fields drive output ports directly.

Top module: `spi_regbank`

## Requirements
- R1: Frame bits go MSB first and are sampled on rising serial-clock edges. Bit 23 is 1 for a read and 0 for a write. Bits 22:17 are the address, bits 16:1 are the data and bit 0 is the check bit. A valid write updates its register only after chip select rises.
- R2: During a read the serial output changes on falling edges. It presents the register value in frame bits 16:1, with register bit 15 in frame bit 16. In every other bit position, and while chip select is high, the output is 0. A write frame returns all zeros.
- R3: Register 0x00 reads 0x0A in bits 11:4 and the revision (default 1) in bits 3:0. These bits ignore writes, so with checking off the register reads 0x00A1.
- R4: A frame with fewer than 24 rising edges sets alarm bit 14 (register 0x01) and changes no control register.
- R5: A frame with more than 24 rising edges sets alarm bit 13 and changes no control register.
- R6: A complete frame addressed outside 0x00–0x06 and 0x0C sets alarm bit 12. A write to such an address is dropped, and a read of one returns 0.
- R7: While register 0x00 bit 15 (check enable) is 1, the ones count over frame bits 23:0 must be odd. Otherwise alarm bit 15 is set and a write is blocked. While the enable is 0, bit 0 is ignored.
- R8: Alarm bits stay set until the host writes register 0x01 with a 1 in the bit's position. A 0 written there leaves the bit unchanged.
- R9: A valid write to register 0x00 with bit 14 set clears the check enable and registers 0x02–0x06 to zero. Bit 15 of that same write is dropped and bit 14 reads back 0. Alarms are kept.
- R10: Register 0x03 bits 8:0 drive the enable outputs. Writing 0 to the register clears them all, and its upper bits read 0.
- R11: Register 0x04 bits 7:0 drive the linearizer output. Register 0x05 bit 10 drives the sideband output, bits 7:4 the Q trim and bits 3:0 the I trim. Unused bits read 0.
- R12: Register 0x02 bits 15:12 drive the alarm-mask output and register 0x06 bits 3:0 drive the converter-control output. Register 0x0C reads the 9-bit converter input in bits 8:0 and ignores writes.
- R13: While rst is high (synchronous, active high), all control outputs and alarms are 0 and the serial output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| adc_word_i | input | 9 | Converter status and value, read at 0x0C |
| parity_en_o | output | 1 | Frame check enable |
| en_o | output | 9 | Function enable bits |
| lin_o | output | 8 | Linearizer setting |
| sideband_o | output | 1 | Sideband select |
| q_trim_o | output | 4 | Q path phase trim |
| i_trim_o | output | 4 | I path phase trim |
| adc_ctrl_o | output | 4 | Converter control bits |
| alarm_mask_o | output | 4 | Alarm mask bits |

## Verification
A write to register 0x00 can update the check enable and fire the soft reset in the same clock cycle. The bench sends 0xC000 there, with correct parity, while checking is on. It expects every control output to be zero afterward, with the check enable cleared and the identity word alone on readback. Random traffic then mixes reset writes, parity toggles, bad lengths and wild addresses. A bench model decides for each frame whether the reset, the write or the drop wins, and the bench compares the ports and the readback words against that model.

// File: rtl/spi_regbank_pkg.sv
`timescale 1ns/1ps
package spi_regbank_pkg;

    localparam int FRAME_W  = 24;
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 16;
    localparam int HDR_W    = 1 + ADDR_W;
    localparam int CNT_SAT  = FRAME_W + 1;
    localparam int CNT_W    = $clog2(CNT_SAT + 1);
    localparam int NWORD    = 7;
    localparam int IDX_W    = $clog2(NWORD);
    localparam int AL_W     = 4;
    localparam int ADC_W    = 9;

    localparam logic [ADDR_W-1:0] A_IDENT  = 6'h00;
    localparam logic [ADDR_W-1:0] A_ALARM  = 6'h01;
    localparam logic [ADDR_W-1:0] A_MASK   = 6'h02;
    localparam logic [ADDR_W-1:0] A_ENABLE = 6'h03;
    localparam logic [ADDR_W-1:0] A_LIN    = 6'h04;
    localparam logic [ADDR_W-1:0] A_LO     = 6'h05;
    localparam logic [ADDR_W-1:0] A_ADC    = 6'h06;
    localparam logic [ADDR_W-1:0] A_ADCOUT = 6'h0C;

    localparam logic [7:0] CHIP_ID = 8'h0A;

    // alarm bit order inside the 4-bit field at word bits 15:12
    localparam int AL_PARITY = 3;
    localparam int AL_SHORT  = 2;
    localparam int AL_LONG   = 1;
    localparam int AL_RANGE  = 0;

    localparam int SRST_BIT  = 14;

    typedef logic [FRAME_W-1:0] fbits_t;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              par;
    } frame_t;

    typedef enum logic [1:0] {
        LEN_OK    = 2'd0,
        LEN_SHORT = 2'd1,
        LEN_LONG  = 2'd2
    } len_e;

    typedef struct packed {
        logic       parity_en;
        logic [3:0] alarm_mask;
        logic [8:0] enable;
        logic [7:0] lin;
        logic       sideband;
        logic [3:0] q_trim;
        logic [3:0] i_trim;
        logic [3:0] adc_ctrl;
    } ctrl_t;

    // bits that hold state in each stored word
    function automatic logic [DATA_W-1:0] wmask(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return 16'h8000;
            3'd2:    return 16'hF000;
            3'd3:    return 16'h01FF;
            3'd4:    return 16'h00FF;
            3'd5:    return 16'h04FF;
            3'd6:    return 16'h000F;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic addr_known(input logic [ADDR_W-1:0] a);
        return (a <= A_ADC) || (a == A_ADCOUT);
    endfunction

    function automatic logic odd_ones(input frame_t f);
        return ^fbits_t'(f);
    endfunction

endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
module spi_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    generate
        if (STAGES <= 1) begin : g_single
            logic [WIDTH-1:0] stg_q;
            always_ff @(posedge clk) begin
                if (rst) stg_q <= RST_VAL;
                else     stg_q <= d_i;
            end
            assign q_o = stg_q;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stg_q;
            always_ff @(posedge clk) begin
                if (rst) stg_q <= {STAGES{RST_VAL}};
                else     stg_q <= {stg_q[STAGES-2:0], d_i};
            end
            assign q_o = stg_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/spi_frame_rx.sv
`timescale 1ns/1ps
module spi_frame_rx
    import spi_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              frame_v_o,
    output frame_t            frame_o,
    output len_e              len_o,
    output logic              miso_o
);

    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(CNT_SAT);

    logic              sclk_d, cs_n_d;
    logic              rise, fall, cs_start, cs_end, active;
    fbits_t            shift_q, frame_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              load_q;
    logic [DATA_W-1:0] tx_q;
    logic              miso_q, frame_v_q;
    len_e              len_q;

    assign rise     = sclk_s & ~sclk_d;
    assign fall     = ~sclk_s & sclk_d;
    assign cs_start = ~cs_n_s & cs_n_d;
    assign cs_end   = cs_n_s & ~cs_n_d;
    assign active   = ~cs_n_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d    <= 1'b0;
            cs_n_d    <= 1'b1;
            shift_q   <= '0;
            frame_q   <= '0;
            cnt_q     <= '0;
            load_q    <= 1'b0;
            tx_q      <= '0;
            miso_q    <= 1'b0;
            frame_v_q <= 1'b0;
            len_q     <= LEN_OK;
        end else begin
            sclk_d    <= sclk_s;
            cs_n_d    <= cs_n_s;
            frame_v_q <= 1'b0;
            load_q    <= 1'b0;
            if (cs_start) begin
                cnt_q  <= '0;
                miso_q <= 1'b0;
            end else if (active && rise) begin
                shift_q <= {shift_q[FRAME_W-2:0], mosi_s};
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_HDR - 1'b1) load_q <= 1'b1;
            end
            if (active && fall) begin
                if (cnt_q >= CNT_HDR && cnt_q < CNT_LAST) begin
                    miso_q <= tx_q[DATA_W-1];
                    tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
                end else begin
                    miso_q <= 1'b0;
                end
            end
            if (load_q) tx_q <= shift_q[ADDR_W] ? rd_data_i : '0;
            if (cs_end) begin
                frame_v_q <= 1'b1;
                frame_q   <= shift_q;
                miso_q    <= 1'b0;
                if (cnt_q == CNT_FULL)     len_q <= LEN_OK;
                else if (cnt_q < CNT_FULL) len_q <= LEN_SHORT;
                else                       len_q <= LEN_LONG;
            end
        end
    end

    assign rd_addr_o = shift_q[ADDR_W-1:0];
    assign frame_v_o = frame_v_q;
    assign frame_o   = frame_t'(frame_q);
    assign len_o     = len_q;
    assign miso_o    = miso_q;

    // R2: output stays low while chip select is idle
    assert_miso_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (cs_n_s && cs_n_d) |-> !miso_q);
    // R2: read word is captured right after the header
    assert_load_after_hdr_R2: assert property (@(posedge clk) disable iff (rst)
        load_q |-> (cnt_q == CNT_HDR));
    // R1: one frame-end pulse per chip-select release
    assert_frame_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        frame_v_q |=> !frame_v_q);
    // R5: edge counter saturates just past a full frame
    assert_cnt_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX);

endmodule

// File: rtl/spi_regfile.sv
`timescale 1ns/1ps
module spi_regfile
    import spi_regbank_pkg::*;
#(
    parameter logic [3:0] REVISION = 4'h1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_v_i,
    input  frame_t            frame_i,
    input  len_e              len_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [ADC_W-1:0]  adc_word_i,
    output logic [DATA_W-1:0] rd_data_o,
    output ctrl_t             ctrl_o
);

    logic [DATA_W-1:0] word_q [NWORD];
    logic [AL_W-1:0]   alarm_q;
    logic              len_ok, par_bad, range_bad, wr_en, soft_rst;
    logic [AL_W-1:0]   alarm_set, alarm_clr;
    logic [IDX_W-1:0]  wr_idx;

    assign len_ok    = frame_v_i && (len_i == LEN_OK);
    assign par_bad   = len_ok && word_q[0][15] && !odd_ones(frame_i);
    assign range_bad = len_ok && !addr_known(frame_i.addr);
    assign wr_en     = len_ok && !frame_i.rd && !par_bad && !range_bad;
    assign soft_rst  = wr_en && (frame_i.addr == A_IDENT) && frame_i.data[SRST_BIT];
    assign wr_idx    = frame_i.addr[IDX_W-1:0];

    always_comb begin
        alarm_set            = '0;
        alarm_set[AL_PARITY] = par_bad;
        alarm_set[AL_SHORT]  = frame_v_i && (len_i == LEN_SHORT);
        alarm_set[AL_LONG]   = frame_v_i && (len_i == LEN_LONG);
        alarm_set[AL_RANGE]  = range_bad;
        alarm_clr = (wr_en && frame_i.addr == A_ALARM) ? frame_i.data[15:12] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            for (int i = 0; i < NWORD; i++) word_q[i] <= '0;
        end else if (wr_en && frame_i.addr < ADDR_W'(NWORD)) begin
            word_q[wr_idx] <= frame_i.data & wmask(wr_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) alarm_q <= '0;
        else     alarm_q <= (alarm_q & ~alarm_clr) | alarm_set;
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i < ADDR_W'(NWORD)) rd_data_o = word_q[rd_addr_i[IDX_W-1:0]];
        case (rd_addr_i)
            A_IDENT:  rd_data_o = rd_data_o | {4'h0, CHIP_ID, REVISION};
            A_ALARM:  rd_data_o = {alarm_q, 12'h000};
            A_ADCOUT: rd_data_o = {7'h00, adc_word_i};
            default:  ;
        endcase
    end

    always_comb begin
        ctrl_o.parity_en  = word_q[0][15];
        ctrl_o.alarm_mask = word_q[A_MASK[IDX_W-1:0]][15:12];
        ctrl_o.enable     = word_q[A_ENABLE[IDX_W-1:0]][8:0];
        ctrl_o.lin        = word_q[A_LIN[IDX_W-1:0]][7:0];
        ctrl_o.sideband   = word_q[A_LO[IDX_W-1:0]][10];
        ctrl_o.q_trim     = word_q[A_LO[IDX_W-1:0]][7:4];
        ctrl_o.i_trim     = word_q[A_LO[IDX_W-1:0]][3:0];
        ctrl_o.adc_ctrl   = word_q[A_ADC[IDX_W-1:0]][3:0];
    end

    assert_short_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (frame_v_i && len_i == LEN_SHORT) |=> ($stable(ctrl_o) && alarm_q[AL_SHORT]));
    assert_long_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (frame_v_i && len_i == LEN_LONG) |=> ($stable(ctrl_o) && alarm_q[AL_LONG]));
    assert_range_flag_R6: assert property (@(posedge clk) disable iff (rst)
        range_bad |=> ($stable(ctrl_o) && alarm_q[AL_RANGE]));
    assert_parity_block_R7: assert property (@(posedge clk) disable iff (rst)
        par_bad |=> ($stable(ctrl_o) && alarm_q[AL_PARITY]));
    assert_alarm_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        !frame_v_i |=> $stable(alarm_q));
    assert_soft_reset_R9: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (ctrl_o == '0));

endmodule

// File: rtl/spi_regbank.sv
`timescale 1ns/1ps
module spi_regbank
    import spi_regbank_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] REVISION    = 4'h1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spi_sclk,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    output logic             spi_miso,
    input  logic [ADC_W-1:0] adc_word_i,
    output logic             parity_en_o,
    output logic [8:0]       en_o,
    output logic [7:0]       lin_o,
    output logic             sideband_o,
    output logic [3:0]       q_trim_o,
    output logic [3:0]       i_trim_o,
    output logic [3:0]       adc_ctrl_o,
    output logic [3:0]       alarm_mask_o
);

    logic [2:0]        sync_q;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              frame_v;
    frame_t            frame;
    len_e              len;
    ctrl_t             ctrl;

    spi_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d_i({spi_sclk, spi_cs_n, spi_mosi}),
        .q_o(sync_q)
    );

    spi_frame_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .sclk_s   (sync_q[2]),
        .cs_n_s   (sync_q[1]),
        .mosi_s   (sync_q[0]),
        .rd_data_i(rd_data),
        .rd_addr_o(rd_addr),
        .frame_v_o(frame_v),
        .frame_o  (frame),
        .len_o    (len),
        .miso_o   (spi_miso)
    );

    spi_regfile #(
        .REVISION(REVISION)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .frame_v_i (frame_v),
        .frame_i   (frame),
        .len_i     (len),
        .rd_addr_i (rd_addr),
        .adc_word_i(adc_word_i),
        .rd_data_o (rd_data),
        .ctrl_o    (ctrl)
    );

    assign parity_en_o  = ctrl.parity_en;
    assign en_o         = ctrl.enable;
    assign lin_o        = ctrl.lin;
    assign sideband_o   = ctrl.sideband;
    assign q_trim_o     = ctrl.q_trim;
    assign i_trim_o     = ctrl.i_trim;
    assign adc_ctrl_o   = ctrl.adc_ctrl;
    assign alarm_mask_o = ctrl.alarm_mask;

endmodule

// File: tb/spi_regbank_tb.sv
`timescale 1ns/1ps
module spi_regbank_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso;
    logic [8:0] adc_word = 9'h000;
    logic       parity_en;
    logic [8:0] en;
    logic [7:0] lin;
    logic       sideband;
    logic [3:0] q_trim, i_trim, adc_ctrl, alarm_mask;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    spi_regbank u_dut (
        .clk(clk), .rst(rst),
        .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
        .adc_word_i(adc_word),
        .parity_en_o(parity_en), .en_o(en), .lin_o(lin), .sideband_o(sideband),
        .q_trim_o(q_trim), .i_trim_o(i_trim), .adc_ctrl_o(adc_ctrl),
        .alarm_mask_o(alarm_mask)
    );

    // bench model of the register state
    logic [15:0] m_w [7];
    logic [3:0]  m_al;

    function automatic logic [15:0] bmask(input int a);
        case (a)
            0: return 16'h8000;
            2: return 16'hF000;
            3: return 16'h01FF;
            4: return 16'h00FF;
            5: return 16'h04FF;
            6: return 16'h000F;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] m_read(input logic [5:0] a);
        if (a == 6'd0) return m_w[0] | 16'h00A1;
        if (a == 6'd1) return {m_al, 12'h000};
        if (a >= 6'd2 && a <= 6'd6) return m_w[a];
        if (a == 6'h0C) return {7'h00, adc_word};
        return 16'h0000;
    endfunction

    function automatic string rtag(input logic [5:0] a);
        case (a)
            6'd0: return "R3";
            6'd1: return "R8";
            6'd3: return "R10";
            6'd4, 6'd5: return "R11";
            6'd2, 6'd6, 6'h0C: return "R12";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input int n, input logic [23:0] f, output logic [23:0] rx);
        rx = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            mosi = (i < 24) ? f[23-i] : 1'b0;
            repeat (5) @(negedge clk);
            if (i < 24) rx[23-i] = miso;
            sclk = 1'b1;
            repeat (5) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (5) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_frame(input int n, input bit rd, input logic [5:0] a,
                            input logic [15:0] d, input bit bad_par, input string tag);
        logic [22:0] hdr;
        logic        p;
        logic [23:0] rx;
        logic [15:0] exp;
        bit          pb, rb;
        hdr = {rd, a, d};
        p   = ~(^hdr) ^ bad_par;
        exp = m_read(a);
        xfer(n, {hdr, p}, rx);
        if (rd && n >= 24) check(tag, {8'h0, rx}, {8'h0, 7'h00, exp, 1'b0});
        if (n < 24) m_al[2] = 1'b1;
        else if (n > 24) m_al[1] = 1'b1;
        else begin
            pb = m_w[0][15] && !(^{hdr, p});
            rb = !((a <= 6'd6) || (a == 6'h0C));
            if (pb) m_al[3] = 1'b1;
            if (rb) m_al[0] = 1'b1;
            if (!rd && !pb && !rb) begin
                if (a == 6'd0) begin
                    if (d[14]) for (int k = 0; k < 7; k++) m_w[k] = 16'h0;
                    else m_w[0] = d & 16'h8000;
                end else if (a == 6'd1) begin
                    m_al = m_al & ~d[15:12];
                end else if (a <= 6'd6) begin
                    m_w[a] = d & bmask(int'(a));
                end
            end
        end
    endtask

    task automatic check_outs();
        check("R7 parity_en", {31'h0, parity_en}, {31'h0, m_w[0][15]});
        check("R10 en", {23'h0, en}, {23'h0, m_w[3][8:0]});
        check("R11 lin", {24'h0, lin}, {24'h0, m_w[4][7:0]});
        check("R11 lo", {20'h0, sideband, 2'b00, q_trim, i_trim},
              {20'h0, m_w[5][10], 2'b00, m_w[5][7:4], m_w[5][3:0]});
        check("R12 ctl", {24'h0, alarm_mask, adc_ctrl},
              {24'h0, m_w[2][15:12], m_w[6][3:0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [5:0]  a;
        logic [15:0] d;
        int          n;
        bit          rd, bp;
        void'($urandom(32'h5EED1));
        for (int k = 0; k < 7; k++) m_w[k] = 16'h0;
        m_al = 4'h0;
        repeat (5) @(negedge clk);
        // R13: outputs during reset
        check("R13 rst outs", {15'h0, en, lin, miso}, 32'h0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check_outs();
        check("R13 miso idle", {31'h0, miso}, 32'h0);

        // R3: identity word
        do_frame(24, 1, 6'd0, 16'h0, 0, "R3");
        check("R3 ident", {16'h0, m_read(6'd0)}, 32'h00A1);
        do_frame(24, 0, 6'd0, 16'h0FFF, 0, "R3");
        do_frame(24, 1, 6'd0, 16'h0, 0, "R3 ro");
        do_frame(24, 1, 6'd1, 16'h0, 0, "R13 alarm0");

        // R10 / R1: enables, then writing zero
        do_frame(24, 0, 6'd3, 16'hFFFF, 0, "R1");
        check("R10 all on", {23'h0, en}, 32'h1FF);
        do_frame(24, 1, 6'd3, 16'h0, 0, "R10");
        do_frame(24, 0, 6'd3, 16'h0000, 0, "R10");
        check("R10 all off", {23'h0, en}, 32'h0);

        // R11: trim register
        do_frame(24, 0, 6'd5, 16'hFFFF, 0, "R11");
        do_frame(24, 1, 6'd5, 16'h0, 0, "R11 readback");
        check("R11 lo fields", {20'h0, sideband, 2'b00, q_trim, i_trim}, 32'h4FF);
        do_frame(24, 0, 6'd4, 16'h5AC3, 0, "R11");
        check("R11 lin", {24'h0, lin}, 32'hC3);

        // R4: short frame, then clear
        do_frame(10, 0, 6'd4, 16'h0011, 0, "R4");
        check("R4 lin kept", {24'h0, lin}, 32'hC3);
        do_frame(24, 1, 6'd1, 16'h0, 0, "R4 alarm");
        check("R4 alarm bit", {28'h0, m_al}, 32'h4);
        do_frame(24, 0, 6'd1, 16'h0000, 0, "R8");
        do_frame(24, 1, 6'd1, 16'h0, 0, "R8 zero keeps");
        do_frame(24, 0, 6'd1, 16'h4000, 0, "R8");
        do_frame(24, 1, 6'd1, 16'h0, 0, "R8 cleared");

        // R5: long frame
        do_frame(28, 0, 6'd4, 16'h0022, 0, "R5");
        check("R5 lin kept", {24'h0, lin}, 32'hC3);
        do_frame(24, 1, 6'd1, 16'h0, 0, "R5 alarm");

        // R6: unknown addresses
        do_frame(24, 0, 6'h20, 16'hFFFF, 0, "R6");
        do_frame(24, 1, 6'h07, 16'h0, 0, "R6 read zero");
        do_frame(24, 1, 6'd1, 16'h0, 0, "R6 alarm");
        check("R6 alarm bits", {28'h0, m_al}, 32'h3);
        do_frame(24, 0, 6'd1, 16'hF000, 0, "R8");

        // R12: converter readback ignores writes
        adc_word = 9'h1A5;
        do_frame(24, 0, 6'h0C, 16'hFFFF, 0, "R12");
        do_frame(24, 1, 6'h0C, 16'h0, 0, "R12 adc");
        do_frame(24, 0, 6'd6, 16'hFFFF, 0, "R12");
        do_frame(24, 0, 6'd2, 16'hFFFF, 0, "R12");
        check("R12 outs", {24'h0, alarm_mask, adc_ctrl}, 32'hFF);

        // R7: parity checking
        do_frame(24, 0, 6'd0, 16'h8000, 1, "R7");
        check("R7 enabled", {31'h0, parity_en}, 32'h1);
        do_frame(24, 0, 6'd4, 16'h0077, 1, "R7");
        check("R7 blocked", {24'h0, lin}, 32'hC3);
        do_frame(24, 1, 6'd1, 16'h0, 0, "R7 alarm");
        check("R7 alarm bit", {28'h0, m_al}, 32'h8);
        do_frame(24, 0, 6'd4, 16'h0077, 0, "R7");
        check("R7 good write", {24'h0, lin}, 32'h77);

        // R9: soft reset lands with check-enable bit in the same write
        do_frame(24, 0, 6'd0, 16'hC000, 0, "R9");
        check("R9 parity off", {31'h0, parity_en}, 32'h0);
        check("R9 outs zero", {4'h0, en, lin, alarm_mask, adc_ctrl, sideband, 2'b00},
              32'h0);
        do_frame(24, 1, 6'd0, 16'h0, 0, "R9 ident");
        do_frame(24, 1, 6'd1, 16'h0, 0, "R9 alarms kept");
        check_outs();

        // random traffic against the model
        for (int it = 0; it < 150; it++) begin
            int pick;
            pick = int'($urandom_range(0, 9));
            case (pick)
                0: a = 6'($urandom);
                1: a = 6'h0C;
                default: a = 6'($urandom_range(0, 6));
            endcase
            d  = 16'($urandom);
            if (a == 6'd0 && $urandom_range(0, 3) != 0) d[14] = 1'b0;
            rd = ($urandom_range(0, 2) == 0);
            n  = 24;
            if ($urandom_range(0, 9) == 0)
                n = ($urandom_range(0, 1) == 0) ? int'($urandom_range(5, 23))
                                                : int'($urandom_range(25, 30));
            bp = ($urandom_range(0, 9) == 0);
            adc_word = 9'($urandom);
            do_frame(n, rd, a, d, bp, rtag(a));
            check_outs();
        end
        do_frame(24, 1, 6'd1, 16'h0, 0, "R8 final");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule